// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block is a memory-mapped pulse-width modulator with four independent outputs. Software configures each output through a single 32-bit configuration word. The word holds a run flag, an 8-bit high-time value and a 13-bit clock divider. A plain synchronous write strobe with an address and a data word updates the configuration. Reads are combinational from the address.

Each channel divides the system clock by its divider value plus one. It steps an 8-bit period counter once per divided tick, so one period is always 256 ticks. The output is high while the counter is below the high-time value. A new high-time or divider value written while a channel runs is held back until the counter wraps, so a period is never cut short or stretched.

Each channel is governed by a two-state machine:
- `CH_OFF`: idle, output low, counters at zero.
- `CH_RUN`: counting.

Its transitions are:
- ENABLE (`CH_OFF` to `CH_RUN`): taken when the run flag is seen set. It captures the live configuration into the channel's working copy.
- DISABLE (`CH_RUN` to `CH_OFF`): taken when the run flag is seen clear.
- IDLE (`CH_OFF` to `CH_OFF`): the run flag stays clear.
- WRAP (`CH_RUN` to `CH_RUN`): the period counter passes from 255 to 0 and the live configuration is captured again.

Top module: `pwmc_top`

## Requirements
- R1: Channel n (n = 0..3) has its configuration word at byte address 16·n. A write to any other address changes nothing, and a read of any other address returns zero.
- R2: Word layout: bit 31 is the run flag, bits 23:16 the high-time value, bits 12:0 the divider. All other bits read as zero whatever was written.
- R3: A read returns the defined fields last written. Writing zero clears the run flag, high-time and divider, so a read-modify-write of the run flag leaves the other fields intact.
- R4: With divider N, the period counter advances once every N+1 clocks. A full period therefore lasts 256·(N+1) clocks, and the output is high for exactly duty·(N+1) clocks of it.
- R5: While running, the output is high exactly when the period counter is below the captured high-time value. A high-time of 0 gives a constant low output, and 255 gives one low tick per period.
- R6: While a channel is stopped, its output is low and both of its counters are zero. If a write sets the run flag at clock edge k, the first period starts at count 0 after edge k+1. If a write clears the flag at edge k, the output is low after edge k+1.
- R7: A high-time or divider written while a channel runs takes effect only when the period counter wraps from 255 to 0.
- R8: The four channels run independently, each on its own configuration.
- R9: Reset clears every configuration word to zero and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The bench goes after the following corner cases:
- High-time 0 and 255: a compare off by one would leave a stray pulse at 0 or drop the single low tick at 255.
- Dividers of 0 and above: a divide-by-N error shows up as a wrong high count in a full-period window.
- Writes to in-stride and out-of-range addresses: a loose decoder would alias them onto a channel.
- Mid-run changes of high-time and divider: applying them at once instead of at the wrap would produce a cut or merged pulse in the cycle-by-cycle comparison.
- Enable, disable and reset in mid-period: a counter not cleared on stop would restart the next period at a nonzero phase.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int REG_W       = 32;
    localparam int DUTY_W      = 8;
    localparam int SCALE_W     = 13;
    localparam int EN_BIT      = 31;
    localparam int DUTY_LSB    = 16;
    localparam int SCALE_LSB   = 0;
    localparam int STRIDE_LOG2 = 4;
    localparam logic [DUTY_W-1:0] PERIOD_LAST = '1;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic               en;
        logic [DUTY_W-1:0]  duty;
        logic [SCALE_W-1:0] scale;
    } ch_cfg_t;

    function automatic ch_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        ch_cfg_t c;
        c.en    = w[EN_BIT];
        c.duty  = w[DUTY_LSB +: DUTY_W];
        c.scale = w[SCALE_LSB +: SCALE_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input ch_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[EN_BIT]                = c.en;
        w[DUTY_LSB +: DUTY_W]    = c.duty;
        w[SCALE_LSB +: SCALE_W]  = c.scale;
        return w;
    endfunction

endpackage

// File: rtl/pwmc_regfile.sv
module pwmc_regfile
    import pwmc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output ch_cfg_t [NCH-1:0]  cfg
);

    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        return ADDR_W'(idx << STRIDE_LOG2);
    endfunction

    logic [NCH-1:0] hit;
    ch_cfg_t        cfg_q [NCH];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_slot
            assign hit[g] = (bus_addr == slot_addr(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[g] <= '0;
                end else if (bus_wr && hit[g]) begin
                    cfg_q[g] <= cfg_from_word(bus_wdata);
                end
            end

            assign cfg[g] = cfg_q[g];
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) begin
                bus_rdata = cfg_to_word(cfg_q[i]);
            end
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[EN_BIT-1:DUTY_LSB+DUTY_W],
                            bus_wdata[DUTY_LSB-1:SCALE_LSB+SCALE_W]};

endmodule

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler #(
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] limit,
    output logic             tick,
    output logic [WIDTH-1:0] count
);

    logic [WIDTH-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == limit);
    assign tick     = !clr && at_limit;
    assign count    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel
    import pwmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  ch_cfg_t            cfg,
    output logic               pwm,
    output logic               run_o,
    output logic [DUTY_W-1:0]  per_o,
    output logic [SCALE_W-1:0] pre_o,
    output logic [DUTY_W-1:0]  duty_sh_o,
    output logic [SCALE_W-1:0] scale_sh_o
);

    ch_state_e          state_q, state_d;
    logic               counting;
    logic               tick;
    logic               wrap;
    logic               load;
    logic [DUTY_W-1:0]  per_q;
    logic [DUTY_W-1:0]  duty_sh;
    logic [SCALE_W-1:0] scale_sh;

    // next state: ENABLE, DISABLE, IDLE, WRAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:  state_d = cfg.en ? CH_RUN : CH_OFF;
            CH_RUN:  state_d = cfg.en ? CH_RUN : CH_OFF;
            default: state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign counting = (state_q == CH_RUN) && cfg.en;
    assign wrap     = counting && tick && (per_q == PERIOD_LAST);
    assign load     = ((state_q == CH_OFF) && cfg.en) || wrap;

    pwmc_prescaler #(.WIDTH(SCALE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!counting),
        .limit (scale_sh),
        .tick  (tick),
        .count (pre_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (!counting) begin
            per_q <= '0;
        end else if (tick) begin
            per_q <= per_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_sh  <= '0;
            scale_sh <= '0;
        end else if (load) begin
            duty_sh  <= cfg.duty;
            scale_sh <= cfg.scale;
        end
    end

    // outputs
    always_comb begin
        pwm        = (state_q == CH_RUN) && (per_q < duty_sh);
        run_o      = (state_q == CH_RUN);
        per_o      = per_q;
        duty_sh_o  = duty_sh;
        scale_sh_o = scale_sh;
    end

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    ch_cfg_t [NCH-1:0]              cfg;
    logic    [NCH-1:0]              reg_en;
    logic    [NCH-1:0]              ch_run;
    logic    [NCH-1:0][DUTY_W-1:0]  ch_per;
    logic    [NCH-1:0][DUTY_W-1:0]  ch_duty_sh;
    logic    [NCH-1:0][SCALE_W-1:0] ch_pre;
    logic    [NCH-1:0][SCALE_W-1:0] ch_scale_sh;

    pwmc_regfile #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            assign reg_en[g] = cfg[g].en;

            pwmc_channel u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg        (cfg[g]),
                .pwm        (pwm_out[g]),
                .run_o      (ch_run[g]),
                .per_o      (ch_per[g]),
                .pre_o      (ch_pre[g]),
                .duty_sh_o  (ch_duty_sh[g]),
                .scale_sh_o (ch_scale_sh[g])
            );
        end
    endgenerate

endmodule

// File: rtl/pwmc_checker.sv
module pwmc_checker
    import pwmc_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NCH-1:0]               pwm_out,
    input logic [NCH-1:0]               reg_en,
    input logic [NCH-1:0]               ch_run,
    input logic [NCH-1:0][DUTY_W-1:0]   ch_per,
    input logic [NCH-1:0][DUTY_W-1:0]   ch_duty_sh,
    input logic [NCH-1:0][SCALE_W-1:0]  ch_pre,
    input logic [NCH-1:0][SCALE_W-1:0]  ch_scale_sh
);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (!reg_en[g] && $past(!reg_en[g])) |-> !pwm_out[g]); // R6

            AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_run[g] |-> (ch_per[g] == '0 && ch_pre[g] == '0)); // R6

            AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                ch_run[g] |-> (ch_pre[g] <= ch_scale_sh[g])); // R4

            AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_run[g] && $past(ch_run[g]) && $past(ch_pre[g]) != $past(ch_scale_sh[g]))
                |-> $stable(ch_per[g])); // R4

            AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_run[g] && $past(ch_run[g]) && ch_per[g] != '0)
                |-> ($stable(ch_duty_sh[g]) && $stable(ch_scale_sh[g]))); // R7
        end
    endgenerate

endmodule

bind pwmc_top pwmc_checker #(.NCH(NCH)) u_pwmc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_out     (pwm_out),
    .reg_en      (reg_en),
    .ch_run      (ch_run),
    .ch_per      (ch_per),
    .ch_duty_sh  (ch_duty_sh),
    .ch_pre      (ch_pre),
    .ch_scale_sh (ch_scale_sh)
);

// File: tb/pwmc_top_bench.sv
module pwmc_top_bench;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int    checks = 0;
    int    failures = 0;
    string tag = "R9";
    bit    done = 1'b0;

    // behavioural reference state
    int m_en [NCH];
    int m_duty [NCH];
    int m_scale [NCH];
    int m_run [NCH];
    int m_pre [NCH];
    int m_per [NCH];
    int m_dsh [NCH];
    int m_ssh [NCH];

    always #5 clk = ~clk;

    pwmc_top u_pwmc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_en[i] = 0; m_duty[i] = 0; m_scale[i] = 0; m_run[i] = 0;
                m_pre[i] = 0; m_per[i] = 0; m_dsh[i] = 0; m_ssh[i] = 0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (m_run[i] == 0) begin
                    m_pre[i] = 0; m_per[i] = 0;
                    if (m_en[i] != 0) begin
                        m_run[i] = 1; m_dsh[i] = m_duty[i]; m_ssh[i] = m_scale[i];
                    end
                end else if (m_en[i] == 0) begin
                    m_run[i] = 0; m_pre[i] = 0; m_per[i] = 0;
                end else if (m_pre[i] == m_ssh[i]) begin
                    m_pre[i] = 0;
                    if (m_per[i] == 255) begin
                        m_per[i] = 0; m_dsh[i] = m_duty[i]; m_ssh[i] = m_scale[i];
                    end else begin
                        m_per[i] = m_per[i] + 1;
                    end
                end else begin
                    m_pre[i] = m_pre[i] + 1;
                end
            end
            if (bus_wr) begin
                for (int i = 0; i < NCH; i++) begin
                    if (int'(bus_addr) == i * 16) begin
                        m_en[i]    = int'(bus_wdata[31]);
                        m_duty[i]  = int'(bus_wdata[23:16]);
                        m_scale[i] = int'(bus_wdata[12:0]);
                    end
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input int a);
        logic [31:0] w;
        w = '0;
        if ((a % 16) == 0 && (a / 16) < NCH) begin
            w[31]    = (m_en[a/16] != 0);
            w[23:16] = 8'(m_duty[a/16]);
            w[12:0]  = 13'(m_scale[a/16]);
        end
        return w;
    endfunction

    function automatic logic exp_out(input int i);
        return (m_run[i] != 0) && (m_per[i] < m_dsh[i]);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) begin
                check(pwm_out[i] == exp_out(i), tag, 32'(pwm_out[i]), 32'(exp_out(i)));
            end
            check(bus_rdata == exp_rd(int'(bus_addr)), tag, bus_rdata, exp_rd(int'(bus_addr)));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string req);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        check(bus_rdata == e, req, bus_rdata, e);
    endtask

    task automatic count_high(input int ch, input int n, input int e, input string req);
        int c;
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) c++;
        end
        check(c == e, req, 32'(c), 32'(e));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3); #1 rst_n = 1'b1;

        // R9: reset state
        tag = "R9";
        @(negedge clk);
        check(pwm_out == 4'b0, "R9", 32'(pwm_out), 32'h0);
        for (int i = 0; i < NCH; i++) rd_expect(8'(i * 16), 32'h0, "R9");

        // R2: layout and undefined bits
        tag = "R2";
        wr(8'h10, 32'hFFFF_FFFF);
        rd_expect(8'h10, 32'h80FF_1FFF, "R2");
        wr(8'h10, 32'h0);
        rd_expect(8'h10, 32'h0, "R3");
        check(pwm_out[1] == 1'b0, "R6", 32'(pwm_out[1]), 32'h0);

        // R3: stored fields read back while stopped
        tag = "R3";
        wr(8'h20, 32'h0012_0034);
        rd_expect(8'h20, 32'h0012_0034, "R3");

        // R1: decode of in-stride and out-of-range addresses
        tag = "R1";
        wr(8'h24, 32'hFFFF_FFFF);
        rd_expect(8'h20, 32'h0012_0034, "R1");
        rd_expect(8'h24, 32'h0, "R1");
        wr(8'h40, 32'hFFFF_FFFF);
        rd_expect(8'h40, 32'h0, "R1");
        rd_expect(8'h00, 32'h0, "R1");
        rd_expect(8'h30, 32'h0, "R1");
        check(pwm_out == 4'b0, "R1", 32'(pwm_out), 32'h0);

        // R4 / R5 / R8: all four channels running together
        tag = "R8";
        wr(8'h00, 32'h8040_0002);
        wr(8'h10, 32'h8000_0000);
        wr(8'h20, 32'h80FF_0001);
        wr(8'h30, 32'h8001_0000);
        idle(800);
        tag = "R4";
        count_high(0, 768, 192, "R4");
        tag = "R5";
        count_high(1, 256, 0, "R5");
        count_high(2, 512, 510, "R5");
        count_high(3, 256, 1, "R5");

        // R7: mid-period changes apply at the wrap
        tag = "R7";
        idle(100);
        wr(8'h00, 32'h80C8_0002);
        wr(8'h30, 32'h8001_0003);
        idle(1100);
        count_high(0, 768, 600, "R7");
        count_high(3, 1024, 4, "R7");

        // R6: read-modify-write disable, then re-enable
        tag = "R6";
        rd_expect(8'h20, 32'h80FF_0001, "R3");
        wr(8'h20, 32'h80FF_0001 & ~32'h8000_0000);
        @(negedge clk);
        count_high(2, 512, 0, "R6");
        rd_expect(8'h20, 32'h00FF_0001, "R3");
        wr(8'h20, 32'h80FF_0001);
        @(negedge clk);
        check(pwm_out[2] == 1'b0, "R6", 32'(pwm_out[2]), 32'h0);
        @(negedge clk);
        check(pwm_out[2] == 1'b1, "R6", 32'(pwm_out[2]), 32'h1);
        idle(50);

        // R9: reset in mid-run
        tag = "R9";
        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        check(pwm_out == 4'b0, "R9", 32'(pwm_out), 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        for (int i = 0; i < NCH; i++) rd_expect(8'(i * 16), 32'h0, "R9");
        idle(20);
        check(pwm_out == 4'b0, "R9", 32'(pwm_out), 32'h0);

        finish_run();
    end

endmodule